// File: doc/BRIEF.md
# Local SRAM Window Decoder

This block holds the configuration word for a small on-chip SRAM and uses it to route every processor access. The word carries a base address that sits on a 32-Kbyte boundary, a write-protect flag, five access-class mask flags and an enable flag. The routing logic compares each access against the 4-Kbyte window that starts at the base address. It then steers the access to the local SRAM, to the cache path or to the external bus. A write into a protected window is reported as an access error instead.

The processor can only write the configuration word, at control-space offset 0xC04. A separate debug port can both write and read it. The routing logic is purely combinational. The configuration word changes on the clock edge that samples a write strobe. Reset clears only the enable flag; every other field keeps its value across reset.

Top module: `lmem_window_dec`

## Requirements
- R1: After reset the enable flag (bit 0) reads as 0 on the debug port, and no access is routed to the SRAM.
- R2: Reset leaves the base (bits 31:15), the write-protect flag (bit 8) and the class masks (bits 5:1) unchanged.
- R3: Bits 14:9 and 7:6 are reserved. Writes to them are ignored, and debug reads return 0 in those positions.
- R4: A processor write with offset 0xC04 updates the word on the next clock edge. A processor write to any other offset leaves the word unchanged.
- R5: A debug write updates the word on the next clock edge. If a processor write and a debug write arrive in the same cycle, the debug data is stored.
- R6: An access hits the window only when all three of these hold: the enable flag is 1, address bits 31:15 equal the base, and address bits 14:12 are 0.
- R7: The route outputs are one-hot or all zero. With accValid low, all four outputs are 0.
- R8: Routing priority is SRAM on a hit, otherwise cache when accCacheable is 1, otherwise external.
- R9: When write protect (bit 8) is 1, a write that hits the window raises accessError and asserts no select. A read that hits the window still selects the SRAM.
- R10: The class code picks a mask bit as follows: 0 is C/I (bit 1), 1 is SC (bit 2), 2 is SD (bit 3), 3 is UC (bit 4), 4 is UD (bit 5). Codes 5 to 7 are never masked. A set mask bit turns a hit into a miss, so the access falls through to cache or external.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset (clears the enable flag only) |
| cpuWrEn | input | 1 | Processor control-space write strobe |
| cpuWrOff | input | 12 | Processor control-space offset |
| cpuWrData | input | 32 | Processor write data |
| dbgWrEn | input | 1 | Debug write strobe |
| dbgWrData | input | 32 | Debug write data |
| dbgRdData | output | 32 | Configuration word as seen by debug, reserved bits zero |
| accValid | input | 1 | Access present this cycle |
| accAddr | input | 32 | Access address |
| accWrite | input | 1 | 1 for a write, 0 for a read |
| accClass | input | 3 | Access class code (see R10) |
| accCacheable | input | 1 | Access space is cacheable |
| sramSel | output | 1 | Route to local SRAM |
| cacheSel | output | 1 | Route to cache path |
| extSel | output | 1 | Route to external bus |
| accessError | output | 1 | Write to a write-protected window |

## Verification
The bench probes the edges of the 4-Kbyte window: the last word inside it, the first address with bit 12 set, and an address whose bits 14:12 are all ones. A decoder that compared only bits 31:15 would claim all 32 Kbytes for the SRAM.

The bench also covers the following cases:
- A processor write and a debug write in the same cycle. A design that let the processor win would store the wrong base.
- A reset after the word has been programmed. A design that cleared every field would lose the base and the write-protect flag.
- A protected write. A design that still raised sramSel on such a write would corrupt the SRAM.
- Class masking. A design that indexed the wrong mask bit would route a masked class to the SRAM.

// File: rtl/lmem_window_pkg.sv
package lmem_window_pkg;
  localparam int DATA_W    = 32;
  localparam int OFF_W     = 12;
  localparam int BASE_LSB  = 15;
  localparam int WIN_LSB   = 12;
  localparam int WP_BIT    = 8;
  localparam int N_CLASS   = 5;
  localparam int CLASS_W   = 3;
  localparam int MASK_LSB  = 1;
  localparam logic [DATA_W-1:0] WRITABLE = 32'hFFFF_813F;

  typedef struct packed {
    logic              load;
    logic [DATA_W-1:0] data;
  } regStrobe_t;
endpackage

// File: rtl/lmem_window_ctrl.sv
module lmem_window_ctrl
  import lmem_window_pkg::*;
#(
  parameter logic [OFF_W-1:0] REG_OFFSET = 12'hC04
) (
  input  logic              cpuWrEn,
  input  logic [OFF_W-1:0]  cpuWrOff,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic              dbgWrEn,
  input  logic [DATA_W-1:0] dbgWrData,
  output regStrobe_t        strb
);
  logic cpuHit;

  assign cpuHit = cpuWrEn && (cpuWrOff == REG_OFFSET);

  always_comb begin
    strb.load = dbgWrEn || cpuHit;
    strb.data = dbgWrEn ? dbgWrData : cpuWrData;
  end

  always_comb begin
    AST_DBG_PRIORITY: assert (!dbgWrEn || strb.data == dbgWrData); // R5
  end
endmodule

// File: rtl/lmem_window_dp.sv
module lmem_window_dp
  import lmem_window_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  regStrobe_t         strb,
  input  logic               accValid,
  input  logic [DATA_W-1:0]  accAddr,
  input  logic               accWrite,
  input  logic [CLASS_W-1:0] accClass,
  input  logic               accCacheable,
  output logic [DATA_W-1:0]  dbgRdData,
  output logic               sramSel,
  output logic               cacheSel,
  output logic               extSel,
  output logic               accessError
);
  localparam int BASE_W = DATA_W - BASE_LSB;
  localparam int GAP_W  = BASE_LSB - WIN_LSB;

  logic [BASE_W-1:0]  baseAddr;
  logic               writeProt;
  logic [N_CLASS-1:0] spaceMask;
  logic               winValid;
  logic               inWindow, classMasked, sramHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          winValid <= 1'b0;
    else if (strb.load) winValid <= strb.data[0];
  end

  always_ff @(posedge clk) begin
    if (rstN && strb.load) begin
      baseAddr  <= strb.data[DATA_W-1:BASE_LSB];
      writeProt <= strb.data[WP_BIT];
      spaceMask <= strb.data[MASK_LSB +: N_CLASS];
    end
  end

  always_comb begin
    dbgRdData = '0;
    dbgRdData[DATA_W-1:BASE_LSB]     = baseAddr;
    dbgRdData[WP_BIT]                = writeProt;
    dbgRdData[MASK_LSB +: N_CLASS]   = spaceMask;
    dbgRdData[0]                     = winValid;
  end

  always_comb begin
    classMasked = 1'b0;
    for (int i = 0; i < N_CLASS; i++)
      if (accClass == CLASS_W'(i)) classMasked = spaceMask[i];
  end

  assign inWindow = winValid
                 && (accAddr[DATA_W-1:BASE_LSB] == baseAddr)
                 && (accAddr[BASE_LSB-1:WIN_LSB] == GAP_W'(0));
  assign sramHit  = inWindow && !classMasked;

  always_comb begin
    sramSel = 1'b0; cacheSel = 1'b0; extSel = 1'b0; accessError = 1'b0;
    if (accValid) begin
      if (sramHit && accWrite && writeProt) accessError = 1'b1;
      else if (sramHit)                     sramSel     = 1'b1;
      else if (accCacheable)                cacheSel    = 1'b1;
      else                                  extSel      = 1'b1;
    end
  end

  AST_ROUTE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({sramSel, cacheSel, extSel, accessError})); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |-> !(sramSel || cacheSel || extSel || accessError)); // R7
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (dbgRdData & ~WRITABLE) == '0); // R3
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> dbgRdData == ($past(strb.data) & WRITABLE)); // R5
  AST_ERR_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    accessError |-> (accWrite && dbgRdData[WP_BIT] && dbgRdData[0])); // R9
  AST_SRAM_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    sramSel |-> dbgRdData[0]); // R6
endmodule

// File: rtl/lmem_window_dec.sv
module lmem_window_dec
  import lmem_window_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuWrEn,
  input  logic [11:0] cpuWrOff,
  input  logic [31:0] cpuWrData,
  input  logic        dbgWrEn,
  input  logic [31:0] dbgWrData,
  output logic [31:0] dbgRdData,
  input  logic        accValid,
  input  logic [31:0] accAddr,
  input  logic        accWrite,
  input  logic [2:0]  accClass,
  input  logic        accCacheable,
  output logic        sramSel,
  output logic        cacheSel,
  output logic        extSel,
  output logic        accessError
);
  regStrobe_t strb;

  lmem_window_ctrl u_ctrl (
    .cpuWrEn(cpuWrEn), .cpuWrOff(cpuWrOff), .cpuWrData(cpuWrData),
    .dbgWrEn(dbgWrEn), .dbgWrData(dbgWrData), .strb(strb)
  );

  lmem_window_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .accValid(accValid), .accAddr(accAddr), .accWrite(accWrite),
    .accClass(accClass), .accCacheable(accCacheable),
    .dbgRdData(dbgRdData), .sramSel(sramSel), .cacheSel(cacheSel),
    .extSel(extSel), .accessError(accessError)
  );
endmodule

// File: tb/lmem_window_dec_tb.sv
module lmem_window_dec_tb;
  logic        clk = 0;
  logic        rstN = 0;
  logic        cpuWrEn = 0;
  logic [11:0] cpuWrOff = 0;
  logic [31:0] cpuWrData = 0;
  logic        dbgWrEn = 0;
  logic [31:0] dbgWrData = 0;
  logic [31:0] dbgRdData;
  logic        accValid = 0;
  logic [31:0] accAddr = 0;
  logic        accWrite = 0;
  logic [2:0]  accClass = 0;
  logic        accCacheable = 0;
  logic        sramSel, cacheSel, extSel, accessError;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  lmem_window_dec u_dut (.*);

  // {addr, write, class, cacheable, expect{sram,cache,ext,err}}
  localparam logic [40:0] VEC [8] = '{
    {32'h2000_8010, 1'b0, 3'd0, 1'b1, 4'b1000},
    {32'h2000_8FFC, 1'b1, 3'd1, 1'b0, 4'b1000},
    {32'h2000_9000, 1'b0, 3'd2, 1'b1, 4'b0100},
    {32'h2000_9000, 1'b0, 3'd2, 1'b0, 4'b0010},
    {32'h2001_0000, 1'b0, 3'd3, 1'b0, 4'b0010},
    {32'h2000_FFFC, 1'b0, 3'd3, 1'b0, 4'b0010},
    {32'h2000_0000, 1'b0, 3'd4, 1'b1, 4'b0100},
    {32'h2000_8000, 1'b1, 3'd4, 1'b0, 4'b1000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic dbgWrite(input logic [31:0] d);
    @(negedge clk); dbgWrEn = 1; dbgWrData = d;
    @(negedge clk); dbgWrEn = 0;
  endtask

  task automatic cpuWrite(input logic [11:0] off, input logic [31:0] d);
    @(negedge clk); cpuWrEn = 1; cpuWrOff = off; cpuWrData = d;
    @(negedge clk); cpuWrEn = 0;
  endtask

  task automatic access(input logic [31:0] a, input logic w, input logic [2:0] c,
                        input logic ca, input string req, input logic [3:0] exp);
    accValid = 1; accAddr = a; accWrite = w; accClass = c; accCacheable = ca;
    #2;
    chk(req, {28'd0, sramSel, cacheSel, extSel, accessError}, {28'd0, exp});
    accValid = 0;
  endtask

  initial begin
    #3_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 enable after reset", {31'd0, dbgRdData[0]}, 32'd0);
    chk("R3 reserved after reset", dbgRdData & ~32'hFFFF_813F, 32'd0);
    access(32'h0000_0000, 0, 0, 0, "R1 no sram after reset", 4'b0010);
    accValid = 0; #2;
    chk("R7 idle outputs", {28'd0, sramSel, cacheSel, extSel, accessError}, 32'd0);
    rstN = 1;

    // R3 reserved bits ignored on write
    dbgWrite(32'hFFFF_FFFF);
    chk("R3 reserved readback", dbgRdData, 32'hFFFF_813F);

    // R4 processor write at register offset
    cpuWrite(12'hC04, 32'h2000_8001);
    chk("R4 cpu write", dbgRdData, 32'h2000_8001);
    cpuWrite(12'hC08, 32'h0000_0000);
    chk("R4 other offset ignored", dbgRdData, 32'h2000_8001);

    @(negedge clk);
    foreach (VEC[i]) begin
      access(VEC[i][40:9], VEC[i][8], VEC[i][7:5], VEC[i][4],
             "R6 R8 vector", VEC[i][3:0]);
      @(negedge clk);
    end

    // R9 write protect
    dbgWrite(32'h2000_8101);
    access(32'h2000_8040, 1, 0, 1, "R9 protected write", 4'b0001);
    access(32'h2000_8040, 0, 0, 1, "R9 protected read", 4'b1000);
    access(32'h2000_9040, 1, 0, 0, "R9 write outside window", 4'b0010);

    // R10 class masking: SD (code 2) -> bit 3
    dbgWrite(32'h2000_8009);
    access(32'h2000_8040, 0, 2, 1, "R10 masked class to cache", 4'b0100);
    access(32'h2000_8040, 0, 2, 0, "R10 masked class to ext", 4'b0010);
    access(32'h2000_8040, 0, 3, 1, "R10 unmasked class", 4'b1000);
    dbgWrite(32'h2000_803F);
    access(32'h2000_8040, 0, 5, 0, "R10 code 5 unmasked", 4'b1000);

    // R5 simultaneous write: debug wins
    @(negedge clk);
    cpuWrEn = 1; cpuWrOff = 12'hC04; cpuWrData = 32'h1111_0001;
    dbgWrEn = 1; dbgWrData = 32'h2000_8001;
    @(negedge clk); cpuWrEn = 0; dbgWrEn = 0;
    chk("R5 debug wins", dbgRdData, 32'h2000_8001);

    // R6 enable flag clear disables window
    dbgWrite(32'h2000_8000);
    access(32'h2000_8040, 0, 0, 0, "R6 disabled window", 4'b0010);

    // R2 reset retains fields
    dbgWrite(32'h4000_8123);
    @(negedge clk); rstN = 0;
    @(negedge clk); rstN = 1;
    chk("R2 retained after reset", dbgRdData, 32'h4000_8122);
    access(32'h4000_8000, 0, 3, 0, "R1 window off after reset", 4'b0010);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule